// File: doc/BRIEF.md
# UART Interrupt Controller

This block gathers the interrupt sources of a serial port into one eleven-bit raw status word, keeps a software mask beside it, and drives six active-high interrupt lines. The receive, transmit, modem-status and line-error paths each raise status bits with one-cycle set pulses. Each transmit-data write also raises the transmit bit. Software reads the raw status, the mask and the masked status through a two-bit register select. It drops pending bits by writing ones to the clear register.

The six lines come from the masked status through fixed group masks. The combined line covers every bit. Receive, transmit and timeout each cover one bit. The modem line covers the four modem-status bits and the error line covers the four line-error bits. Each line is registered, so a line follows a change in raw status or mask one clock later.

Top module: `uart_irq_ctrl`

## Requirements
- R1: A set pulse on `evt_set` bit k sets raw status bit k at the next clock edge. Bit positions: 10 overrun, 9 break, 8 parity, 7 framing, 6 receive timeout, 5 transmit, 4 receive, 3 DSR, 2 DCD, 1 CTS, 0 RI.
- R2: A `tx_wr` pulse sets raw bit 5 at the next clock edge.
- R3: Register select 0 writes and reads the mask. Select 1 reads the raw status. Select 2 reads raw AND mask.
- R4: A write to select 3 clears each raw bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: When a set pulse and a clear write hit the same bit in one cycle, the bit ends up set.
- R6: `irq_all` is high when any masked status bit is set.
- R7: `irq_rx` follows masked bit 4, `irq_tx` masked bit 5, `irq_rt` masked bit 6. `irq_ms` is the OR of masked bits 0 to 3. `irq_err` is the OR of masked bits 7 to 10.
- R8: Any change to raw status or mask shows on the lines one clock edge after the edge that changes the state.
- R9: After reset the mask, the raw status and all six lines are zero.
- R10: Writes to selects 1 and 2 have no effect. A read of select 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_set | input | 11 | Per-bit set pulses from the data, modem and error paths |
| tx_wr | input | 1 | Pulse on each transmit-data write |
| reg_sel | input | 2 | Register select: 0 mask, 1 raw, 2 masked, 3 clear |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 11 | Write data |
| reg_rdata | output | 11 | Read data of the selected register, combinational |
| irq_all | output | 1 | Combined interrupt line |
| irq_rx | output | 1 | Receive interrupt line |
| irq_tx | output | 1 | Transmit interrupt line |
| irq_rt | output | 1 | Receive timeout interrupt line |
| irq_ms | output | 1 | Modem status interrupt line |
| irq_err | output | 1 | Line error interrupt line |

## Verification
The assertions assume that set pulses and register writes are sampled only at the clock edge. They also assume that the clear vector reaching the status register is zero unless a clear write is under way. The stimulus changes every input only on the falling edge and holds each pulse for exactly one cycle. It overlaps set pulses with clear writes on purpose, so that the set-wins rule is exercised. It also covers mask writes with no pending status and a pending status with the mask all zero.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int STAT_W    = 11;
   localparam int NUM_LINES = 6;

   localparam int BIT_RI  = 0;
   localparam int BIT_CTS = 1;
   localparam int BIT_DCD = 2;
   localparam int BIT_DSR = 3;
   localparam int BIT_RX  = 4;
   localparam int BIT_TX  = 5;
   localparam int BIT_RT  = 6;
   localparam int BIT_FE  = 7;
   localparam int BIT_PE  = 8;
   localparam int BIT_BE  = 9;
   localparam int BIT_OE  = 10;

   typedef enum logic [1:0] {
      SEL_MASK   = 2'd0,
      SEL_RAW    = 2'd1,
      SEL_MASKED = 2'd2,
      SEL_CLEAR  = 2'd3
   } reg_sel_e;

   // Line index: 0 combined, 1 rx, 2 tx, 3 timeout, 4 modem, 5 error
   function automatic logic [STAT_W-1:0] line_mask(input int idx);
      logic [STAT_W-1:0] m;
      m = '0;
      case (idx)
         0: m = '1;
         1: m[BIT_RX] = 1'b1;
         2: m[BIT_TX] = 1'b1;
         3: m[BIT_RT] = 1'b1;
         4: m[BIT_DSR:BIT_RI] = '1;
         5: m[BIT_OE:BIT_FE] = '1;
         default: m = '0;
      endcase
      return m;
   endfunction
endpackage

// File: rtl/uart_irq_status.sv
module uart_irq_status #(
   parameter int WIDTH = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] raw_o
);
   logic [WIDTH-1:0] raw_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= (raw_q & ~clr_i) | set_i;
   end

   assign raw_o = raw_q;

   // R1
   set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((raw_o & $past(set_i)) == $past(set_i)));

   // R4
   clear_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i != '0) |=> ((raw_o & $past(clr_i & ~set_i)) == '0));

   // R4
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i == '0 && clr_i == '0) |=> $stable(raw_o));
endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask #(
   parameter int WIDTH = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [WIDTH-1:0] wdata_i,
   output logic [WIDTH-1:0] mask_o
);
   logic [WIDTH-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mask_q <= '0;
      else if (wr_i) mask_q <= wdata_i;
   end

   assign mask_o = mask_q;

   // R3
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (mask_o == $past(wdata_i)));

   // R3
   mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(mask_o));
endmodule

// File: rtl/uart_irq_fanout.sv
module uart_irq_fanout
   import uart_irq_pkg::*;
#(
   parameter int WIDTH = 11,
   parameter int LINES = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] masked_i,
   output logic [LINES-1:0] line_o
);
   logic [LINES-1:0] line_q;

   for (genvar g = 0; g < LINES; g++) begin : g_line
      localparam logic [WIDTH-1:0] GMASK = WIDTH'(line_mask(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) line_q[g] <= 1'b0;
         else        line_q[g] <= |(masked_i & GMASK);
      end
   end

   assign line_o = line_q;

   // R6
   all_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (masked_i != '0) |=> line_o[0]);

   // R6
   all_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (masked_i == '0) |=> (line_o == '0));

   // R7
   group_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|line_o[LINES-1:1]) |-> line_o[0]);
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
   import uart_irq_pkg::*;
#(
   parameter int STAT_BITS = uart_irq_pkg::STAT_W,
   parameter int SEL_W     = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [STAT_BITS-1:0] evt_set,
   input  logic                 tx_wr,
   input  logic [SEL_W-1:0]     reg_sel,
   input  logic                 reg_wr,
   input  logic [STAT_BITS-1:0] reg_wdata,
   output logic [STAT_BITS-1:0] reg_rdata,
   output logic                 irq_all,
   output logic                 irq_rx,
   output logic                 irq_tx,
   output logic                 irq_rt,
   output logic                 irq_ms,
   output logic                 irq_err
);
   localparam int LINES = uart_irq_pkg::NUM_LINES;

   if (STAT_BITS != uart_irq_pkg::STAT_W) begin : g_bad_width
      $error("uart_irq_ctrl: status width must match the fixed bit map");
   end
   if (SEL_W != 2) begin : g_bad_sel
      $error("uart_irq_ctrl: register select must be two bits");
   end

   logic [STAT_BITS-1:0] set_vec;
   logic [STAT_BITS-1:0] clr_vec;
   logic [STAT_BITS-1:0] raw;
   logic [STAT_BITS-1:0] mask;
   logic [STAT_BITS-1:0] masked;
   logic [LINES-1:0]     lines;
   logic                 mask_wr;

   always_comb begin
      set_vec         = evt_set;
      set_vec[BIT_TX] = evt_set[BIT_TX] | tx_wr;
   end

   assign clr_vec = (reg_wr && reg_sel == SEL_CLEAR) ? reg_wdata : '0;
   assign mask_wr = reg_wr && (reg_sel == SEL_MASK);
   assign masked  = raw & mask;

   uart_irq_status #(.WIDTH(STAT_BITS)) u_status (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec),
      .clr_i (clr_vec),
      .raw_o (raw)
   );

   uart_irq_mask #(.WIDTH(STAT_BITS)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (mask_wr),
      .wdata_i (reg_wdata),
      .mask_o  (mask)
   );

   uart_irq_fanout #(.WIDTH(STAT_BITS), .LINES(LINES)) u_fanout (
      .clk      (clk),
      .rst_n    (rst_n),
      .masked_i (masked),
      .line_o   (lines)
   );

   always_comb begin
      case (reg_sel)
         SEL_MASK:   reg_rdata = mask;
         SEL_RAW:    reg_rdata = raw;
         SEL_MASKED: reg_rdata = masked;
         default:    reg_rdata = '0;
      endcase
   end

   assign irq_all = lines[0];
   assign irq_rx  = lines[1];
   assign irq_tx  = lines[2];
   assign irq_rt  = lines[3];
   assign irq_ms  = lines[4];
   assign irq_err = lines[5];

   // R2
   tx_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_wr |=> raw[BIT_TX]);

   // R5
   set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == SEL_CLEAR && evt_set[BIT_RX]) |=> raw[BIT_RX]);

   // R10
   ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && (reg_sel == SEL_RAW || reg_sel == SEL_MASKED)) |=> $stable(mask));

   // R8
   rx_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      masked[BIT_RX] |=> irq_rx);
endmodule

// File: tb/tb_uart_irq_ctrl.sv
module tb_uart_irq_ctrl;
   localparam int W = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [W-1:0]  evt_set = '0;
   logic          tx_wr = 1'b0;
   logic [1:0]    reg_sel = 2'd0;
   logic          reg_wr = 1'b0;
   logic [W-1:0]  reg_wdata = '0;
   logic [W-1:0]  reg_rdata;
   logic irq_all, irq_rx, irq_tx, irq_rt, irq_ms, irq_err;

   uart_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .tx_wr(tx_wr),
      .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_all(irq_all), .irq_rx(irq_rx),
      .irq_tx(irq_tx), .irq_rt(irq_rt), .irq_ms(irq_ms), .irq_err(irq_err)
   );

   always #10 clk = ~clk;

   typedef struct {
      int         cyc;
      logic [5:0] lines;
      string      tag;
   } exp_t;

   exp_t       sb[$];
   int         cyc = 0;
   int         checks = 0;
   int         fails = 0;
   logic [W-1:0] m_raw = '0;
   logic [W-1:0] m_mask = '0;

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   function automatic logic [5:0] exp_lines(input logic [W-1:0] r, input logic [W-1:0] m);
      logic [W-1:0] v;
      v = r & m;
      // {err, modem, timeout, tx, rx, combined}
      return {|v[10:7], |v[3:0], v[6], v[5], v[4], |v};
   endfunction

   function automatic logic [5:0] dut_lines();
      return {irq_err, irq_ms, irq_rt, irq_tx, irq_rx, irq_all};
   endfunction

   // monitor: compare lines against queued expectations
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].cyc <= cyc) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if (e.cyc != cyc || dut_lines() !== e.lines) begin
            fails++;
            $display("FAIL %s lines: actual %b expected %b (cycle %0d)", e.tag, dut_lines(), e.lines, cyc);
         end
      end
   end

   // driver: one-cycle stimulus, model update, expected result queued
   task automatic step(input logic [W-1:0] ev, input logic tx, input logic wr,
                       input logic [1:0] sel, input logic [W-1:0] wd, input string tag);
      exp_t e;
      evt_set = ev; tx_wr = tx; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
      if (wr && sel == 2'd3) m_raw = m_raw & ~wd;
      m_raw = m_raw | ev | (tx ? 11'h020 : 11'h000);
      if (wr && sel == 2'd0) m_mask = wd;
      e.cyc = cyc + 2;
      e.lines = exp_lines(m_raw, m_mask);
      e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
      evt_set = '0; tx_wr = 1'b0; reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, input logic [W-1:0] exp, input string tag);
      reg_sel = sel;
      #1;
      checks++;
      if (reg_rdata !== exp) begin
         fails++;
         $display("FAIL %s read sel %0d: actual %h expected %h", tag, sel, reg_rdata, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step('0, 1'b0, 1'b0, 2'd0, '0, "R8 idle");
   endtask

   initial begin
      #1000000;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      rd(2'd0, '0, "R9 mask");
      rd(2'd1, '0, "R9 raw");
      checks++;
      if (dut_lines() !== 6'b0) begin
         fails++;
         $display("FAIL R9 lines: actual %b expected 000000", dut_lines());
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R7: each bit alone with everything enabled
      step('0, 1'b0, 1'b1, 2'd0, 11'h7FF, "R3 mask all");
      rd(2'd0, 11'h7FF, "R3 mask read");
      for (int b = 0; b < W; b++) begin
         step(11'(1) << b, 1'b0, 1'b0, 2'd0, '0, "R7 single bit");
         rd(2'd1, 11'(1) << b, "R1 raw bit");
         step('0, 1'b0, 1'b1, 2'd3, 11'h7FF, "R4 clear all");
         rd(2'd1, '0, "R4 raw cleared");
      end

      // R2 transmit write
      step('0, 1'b1, 1'b0, 2'd0, '0, "R2 tx write");
      rd(2'd1, 11'h020, "R2 raw tx");

      // R4 partial clear
      step(11'h5A3, 1'b0, 1'b0, 2'd0, '0, "R1 pattern");
      step('0, 1'b0, 1'b1, 2'd3, 11'h0A1, "R4 partial clear");
      rd(2'd1, (11'h5A3 | 11'h020) & ~11'h0A1, "R4 partial raw");

      // R3 / R8 mask changes alone
      step('0, 1'b0, 1'b1, 2'd0, 11'h00F, "R8 mask modem only");
      rd(2'd2, ((11'h5A3 | 11'h020) & ~11'h0A1) & 11'h00F, "R3 masked read");
      step('0, 1'b0, 1'b1, 2'd0, 11'h000, "R6 mask none");
      rd(2'd2, '0, "R3 masked zero");
      step('0, 1'b0, 1'b1, 2'd0, 11'h780, "R7 mask errors");
      step('0, 1'b0, 1'b1, 2'd0, 11'h070, "R7 mask data");

      // R10 writes to read-only selects
      step('0, 1'b0, 1'b1, 2'd1, 11'h7FF, "R10 raw write");
      step('0, 1'b0, 1'b1, 2'd2, 11'h000, "R10 masked write");
      rd(2'd1, m_raw, "R10 raw unchanged");
      rd(2'd0, 11'h070, "R10 mask unchanged");
      rd(2'd3, '0, "R10 clear reads zero");

      // R5 set and clear collide
      step('0, 1'b0, 1'b1, 2'd3, 11'h7FF, "R4 clear all");
      step(11'h010, 1'b0, 1'b1, 2'd3, 11'h010, "R5 set wins rx");
      rd(2'd1, 11'h010, "R5 raw rx");
      step('0, 1'b1, 1'b1, 2'd3, 11'h030, "R5 tx wins");
      rd(2'd1, 11'h020, "R5 raw tx");

      idle(4);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule